// File: doc/BRIEF.md
# UART FIFO Interrupt Status Unit

This block turns the fill state of a UART's receive and transmit FIFOs into interrupt causes. It masks them and drives one interrupt line. The FIFOs, the serial shifters and the baud generator sit outside. They give this unit the two fill levels, push and pop strobes on the receive side, a pulse once per character time, and a pulse whenever a modem input changes. In return the unit holds the thresholds, the idle timeout, the per-cause mask bits and the FIFO reset controls.

Software reaches the unit over a small register bus with three word addresses. Address 0 holds the mask bits and the status bits of the six causes. Address 1 holds the thresholds, the timeout and the self-clearing FIFO reset bits. Address 2 returns the live fill levels, so a driver can work out the free transmit space as the depth minus the level. The receive overrun status is sticky. A write to the status register does not clear it. Only a receive FIFO reset clears it.

Top module: `uart_fifo_irq`

## Requirements
- R1: After reset the mask bits are all 0, both thresholds are DEPTH/2, the timeout is 1 character time, `irq` is low, and address 1 reads with receive threshold in [4:0], transmit threshold in [12:8] and timeout in [19:16].
- R2: `irq` is high exactly when some cause has both its status bit and its mask bit set. At address 0 the mask bits sit in [5:0] and the status bits in [13:8], in this cause order: overrun 0, receive threshold 1, receive timeout 2, transmit empty 3, transmit threshold 4, modem 5.
- R3: The receive threshold status is 1 while the receive level is at or above the programmed receive threshold.
- R4: The transmit empty status is 1 while the transmit level is 0. The transmit threshold status is 1 while the transmit level is below the programmed transmit threshold.
- R5: A receive push while the receive level equals DEPTH sets the overrun status. The status then holds. Writing 1 to its status bit at address 0 leaves it set.
- R6: Writing 1 to bit 24 (receive) or bit 25 (transmit) of address 1 drives `rxFifoRst` or `txFifoRst` high for exactly one cycle. Both bits read back as 0. The receive reset clears the overrun status.
- R7: With a timeout of T>0, the timeout status sets on the T-th character tick during which the receive level stays non-zero with no push or pop. A pop, a push, an empty receive FIFO or a receive reset clears it and restarts the count. T=0 disables it.
- R8: A `modemEvent` pulse sets the modem status. It stays set until a write to address 0 with bit 13 set, which clears it.
- R9: Address 2 reads the transmit level in [4:0] and the receive level in [12:8]. Bit 14 of address 0 reads 1 while the receive level is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register word address |
| regWrEn | input | 1 | Register write strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| rxLevel | input | 5 | Receive FIFO fill level |
| txLevel | input | 5 | Transmit FIFO fill level |
| rxPush | input | 1 | A character is written into the receive FIFO |
| rxPop | input | 1 | A character is read from the receive FIFO |
| charTick | input | 1 | One pulse per character time |
| modemEvent | input | 1 | Edge seen on a modem input |
| rxFifoRst | output | 1 | One-cycle receive FIFO reset |
| txFifoRst | output | 1 | One-cycle transmit FIFO reset |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the unit with DEPTH 16 and a 4-bit timeout field. These are the default values. With them a completely full receive FIFO is reachable, so the overrun path can be exercised, and the timeout counts stay small enough to walk tick by tick. Timeouts of 0, 1 and 3 character times are driven, and a push falls between ticks so the count must restart. The threshold tests probe the levels on each side of the programmed boundary, and the transmit threshold is moved to a second value.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_CAUSES  = 6;
  localparam int C_RX_OVER   = 0;
  localparam int C_RX_THR    = 1;
  localparam int C_RX_TMO    = 2;
  localparam int C_TX_EMPTY  = 3;
  localparam int C_TX_THR    = 4;
  localparam int C_MODEM     = 5;

  localparam int STAT_LSB    = 8;
  localparam int TX_THR_LSB  = 8;
  localparam int TMO_LSB     = 16;
  localparam int RXRST_BIT   = 24;
  localparam int TXRST_BIT   = 25;
  localparam int RXLVL_LSB   = 8;

  typedef struct packed {
    logic rxRst;
    logic txRst;
    logic modemClr;
  } strobe_t;
endpackage

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TMO_W  = 4,
  parameter int DATA_W = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            regAddr,
  input  logic                  regWrEn,
  input  logic [DATA_W-1:0]     regWdata,
  output logic [DATA_W-1:0]     regRdata,
  input  logic [NUM_CAUSES-1:0] statusVec,
  input  logic                  rxNotEmpty,
  input  logic [LVL_W-1:0]      rxLevel,
  input  logic [LVL_W-1:0]      txLevel,
  output logic [NUM_CAUSES-1:0] maskQ,
  output logic [LVL_W-1:0]      rxThrQ,
  output logic [LVL_W-1:0]      txThrQ,
  output logic [TMO_W-1:0]      tmoQ,
  output strobe_t               strobes
);
  localparam logic [LVL_W-1:0] HALF = LVL_W'(DEPTH / 2);

  strobe_t strobeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ   <= '0;
      rxThrQ  <= HALF;
      txThrQ  <= HALF;
      tmoQ    <= TMO_W'(1);
      strobeQ <= '0;
    end else begin
      strobeQ <= '0;
      if (regWrEn) begin
        case (regAddr)
          2'd0: begin
            maskQ            <= regWdata[NUM_CAUSES-1:0];
            strobeQ.modemClr <= regWdata[STAT_LSB + C_MODEM];
          end
          2'd1: begin
            rxThrQ        <= regWdata[LVL_W-1:0];
            txThrQ        <= regWdata[TX_THR_LSB +: LVL_W];
            tmoQ          <= regWdata[TMO_LSB +: TMO_W];
            strobeQ.rxRst <= regWdata[RXRST_BIT];
            strobeQ.txRst <= regWdata[TXRST_BIT];
          end
          default: ;
        endcase
      end
    end
  end

  assign strobes = strobeQ;

  always_comb begin
    regRdata = '0;
    case (regAddr)
      2'd0: begin
        regRdata[NUM_CAUSES-1:0]              = maskQ;
        regRdata[STAT_LSB +: NUM_CAUSES]      = statusVec;
        regRdata[STAT_LSB + NUM_CAUSES]       = rxNotEmpty;
      end
      2'd1: begin
        regRdata[LVL_W-1:0]                   = rxThrQ;
        regRdata[TX_THR_LSB +: LVL_W]         = txThrQ;
        regRdata[TMO_LSB +: TMO_W]            = tmoQ;
      end
      2'd2: begin
        regRdata[LVL_W-1:0]                   = txLevel;
        regRdata[RXLVL_LSB +: LVL_W]          = rxLevel;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/uirq_status.sv
module uirq_status
  import uart_irq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TMO_W  = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobes,
  input  logic [LVL_W-1:0]      rxLevel,
  input  logic [LVL_W-1:0]      txLevel,
  input  logic                  rxPush,
  input  logic                  rxPop,
  input  logic                  charTick,
  input  logic                  modemEvent,
  input  logic [LVL_W-1:0]      rxThr,
  input  logic [LVL_W-1:0]      txThr,
  input  logic [TMO_W-1:0]      tmoChars,
  input  logic [NUM_CAUSES-1:0] maskQ,
  output logic [NUM_CAUSES-1:0] statusVec,
  output logic                  rxNotEmpty,
  output logic                  irq
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic             overQ, tmoStatQ, modemQ;
  logic [TMO_W-1:0] tmoCnt;
  logic             tmoRestart, tickHit;

  assign rxNotEmpty = (rxLevel != '0);

  // Sticky overrun: only the receive reset strobe can clear it.
  always_ff @(posedge clk) begin
    if (!rstN)               overQ <= 1'b0;
    else if (strobes.rxRst)  overQ <= 1'b0;
    else if (rxPush && rxLevel == FULL_LVL) overQ <= 1'b1;
  end

  // Idle timeout in whole character times.
  assign tmoRestart = strobes.rxRst || !rxNotEmpty || rxPush || rxPop;
  assign tickHit    = charTick && (tmoChars != '0) &&
                      (({1'b0, tmoCnt} + 1'b1) >= {1'b0, tmoChars});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmoCnt   <= '0;
      tmoStatQ <= 1'b0;
    end else if (tmoRestart) begin
      tmoCnt   <= '0;
      tmoStatQ <= 1'b0;
    end else begin
      if (charTick && tmoCnt != '1) tmoCnt <= tmoCnt + 1'b1;
      if (tickHit) tmoStatQ <= 1'b1;
    end
  end

  // Modem change: set wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN)                 modemQ <= 1'b0;
    else if (modemEvent)       modemQ <= 1'b1;
    else if (strobes.modemClr) modemQ <= 1'b0;
  end

  always_comb begin
    statusVec             = '0;
    statusVec[C_RX_OVER]  = overQ;
    statusVec[C_RX_THR]   = (rxLevel >= rxThr);
    statusVec[C_RX_TMO]   = tmoStatQ;
    statusVec[C_TX_EMPTY] = (txLevel == '0);
    statusVec[C_TX_THR]   = (txLevel < txThr);
    statusVec[C_MODEM]    = modemQ;
  end

  logic [NUM_CAUSES-1:0] gated;
  for (genvar i = 0; i < NUM_CAUSES; i++) begin : g_gate
    assign gated[i] = statusVec[i] & maskQ[i];
  end
  assign irq = |gated;
endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
  import uart_irq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TMO_W  = 4,
  parameter int DATA_W = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic              rxPush,
  input  logic              rxPop,
  input  logic              charTick,
  input  logic              modemEvent,
  output logic              rxFifoRst,
  output logic              txFifoRst,
  output logic              irq
);
  strobe_t               strobes;
  logic [NUM_CAUSES-1:0] statusVec, maskQ;
  logic                  rxNotEmpty;
  logic [LVL_W-1:0]      rxThrQ, txThrQ;
  logic [TMO_W-1:0]      tmoQ;

  uirq_ctrl #(.DEPTH(DEPTH), .TMO_W(TMO_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWdata(regWdata), .regRdata(regRdata), .statusVec(statusVec),
    .rxNotEmpty(rxNotEmpty), .rxLevel(rxLevel), .txLevel(txLevel),
    .maskQ(maskQ), .rxThrQ(rxThrQ), .txThrQ(txThrQ), .tmoQ(tmoQ),
    .strobes(strobes)
  );

  uirq_status #(.DEPTH(DEPTH), .TMO_W(TMO_W)) status_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rxLevel(rxLevel),
    .txLevel(txLevel), .rxPush(rxPush), .rxPop(rxPop), .charTick(charTick),
    .modemEvent(modemEvent), .rxThr(rxThrQ), .txThr(txThrQ),
    .tmoChars(tmoQ), .maskQ(maskQ), .statusVec(statusVec),
    .rxNotEmpty(rxNotEmpty), .irq(irq)
  );

  assign rxFifoRst = strobes.rxRst;
  assign txFifoRst = strobes.txRst;
endmodule

// File: rtl/uart_fifo_irq_chk.sv
module uart_fifo_irq_chk
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  irq,
  input logic                  rxFifoRst,
  input logic                  txFifoRst,
  input logic [LVL_W-1:0]      rxLevel,
  input logic [LVL_W-1:0]      txLevel,
  input logic [LVL_W-1:0]      rxThr,
  input logic [NUM_CAUSES-1:0] maskQ,
  input logic [NUM_CAUSES-1:0] statusVec
);
  // R2
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irq);
  // R3
  rx_thr_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ[C_RX_THR] && rxLevel >= rxThr) |-> irq);
  // R4
  tx_empty_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ[C_TX_EMPTY] && txLevel == '0) |-> irq);
  // R5
  over_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusVec[C_RX_OVER] && !rxFifoRst) |=> statusVec[C_RX_OVER]);
  // R6
  rx_rst_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxFifoRst |=> !rxFifoRst);
  // R6
  tx_rst_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    txFifoRst |=> !txFifoRst);
  // R7
  tmo_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel == '0) |=> !statusVec[C_RX_TMO]);
endmodule

bind uart_fifo_irq uart_fifo_irq_chk #(.LVL_W(LVL_W)) chk_i (
  .clk(clk), .rstN(rstN), .irq(irq), .rxFifoRst(rxFifoRst),
  .txFifoRst(txFifoRst), .rxLevel(rxLevel), .txLevel(txLevel),
  .rxThr(rxThrQ), .maskQ(maskQ), .statusVec(statusVec)
);

// File: tb/uart_fifo_irq_tb.sv
module uart_fifo_irq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [4:0]  rxLevel = '0, txLevel = '0;
  logic        rxPush = 1'b0, rxPop = 1'b0, charTick = 1'b0, modemEvent = 1'b0;
  logic        rxFifoRst, txFifoRst, irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_fifo_irq dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWdata(regWdata), .regRdata(regRdata), .rxLevel(rxLevel),
    .txLevel(txLevel), .rxPush(rxPush), .rxPop(rxPop), .charTick(charTick),
    .modemEvent(modemEvent), .rxFifoRst(rxFifoRst), .txFifoRst(txFifoRst),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic tick();
    @(negedge clk); charTick = 1'b1;
    @(negedge clk); charTick = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd1, d); chk("R1 control reset", d, 32'h0001_0808);
    rd(2'd0, d); chk("R1 irq reg reset", d, 32'h0000_1800);
    chk("R1 irq low", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_rx_thr();
    logic [31:0] d;
    rxLevel = 5'd7; settle();
    rd(2'd0, d); chk("R3 below threshold", {31'd0, d[9]}, 32'd0);
    rxLevel = 5'd8; settle();
    rd(2'd0, d); chk("R3 at threshold", {31'd0, d[9]}, 32'd1);
    wr(2'd0, 32'h0000_0002);
    chk("R2 irq rx threshold masked in", {31'd0, irq}, 32'd1);
    rxLevel = 5'd7; settle();
    chk("R2 irq drops below threshold", {31'd0, irq}, 32'd0);
    rxLevel = 5'd0; wr(2'd0, 32'h0);
  endtask

  task automatic t_tx();
    logic [31:0] d;
    txLevel = 5'd5; settle();
    rd(2'd0, d); chk("R4 tx level 5 thr 8", {30'd0, d[12:11]}, 32'd2);
    txLevel = 5'd8; settle();
    rd(2'd0, d); chk("R4 tx level 8 thr 8", {30'd0, d[12:11]}, 32'd0);
    wr(2'd1, 32'h0001_0408);
    txLevel = 5'd5; settle();
    rd(2'd0, d); chk("R4 tx level 5 thr 4", {30'd0, d[12:11]}, 32'd0);
    txLevel = 5'd0; wr(2'd0, 32'h0000_0008);
    chk("R4 tx empty irq", {31'd0, irq}, 32'd1);
    wr(2'd0, 32'h0); wr(2'd1, 32'h0001_0808);
    chk("R2 irq off with mask cleared", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    rxLevel = 5'd16;
    @(negedge clk); rxPush = 1'b1;
    @(negedge clk); rxPush = 1'b0;
    rd(2'd0, d); chk("R5 overrun set", {31'd0, d[8]}, 32'd1);
    wr(2'd0, 32'h0000_0101);
    settle();
    rd(2'd0, d); chk("R5 overrun kept after status write", {31'd0, d[8]}, 32'd1);
    chk("R2 irq overrun", {31'd0, irq}, 32'd1);
    // R6 receive reset clears it
    wr(2'd1, 32'h0101_0808);
    chk("R6 rxFifoRst pulse", {31'd0, rxFifoRst}, 32'd1);
    rd(2'd1, d); chk("R6 reset bits read 0", d, 32'h0001_0808);
    rxLevel = 5'd0;
    settle();
    chk("R6 rxFifoRst one cycle", {31'd0, rxFifoRst}, 32'd0);
    rd(2'd0, d); chk("R6 overrun cleared", {31'd0, d[8]}, 32'd0);
    wr(2'd1, 32'h0201_0808);
    chk("R6 txFifoRst pulse", {30'd0, txFifoRst, rxFifoRst}, 32'd2);
    settle();
    chk("R6 txFifoRst one cycle", {31'd0, txFifoRst}, 32'd0);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    rxLevel = 5'd3; settle();
    tick();
    rd(2'd0, d); chk("R7 timeout after 1 char", {31'd0, d[10]}, 32'd1);
    @(negedge clk); rxPop = 1'b1;
    @(negedge clk); rxPop = 1'b0;
    rd(2'd0, d); chk("R7 cleared by pop", {31'd0, d[10]}, 32'd0);
    wr(2'd1, 32'h0003_0808);
    tick(); tick();
    @(negedge clk); rxPush = 1'b1;
    @(negedge clk); rxPush = 1'b0;
    tick(); tick();
    rd(2'd0, d); chk("R7 push restarts count", {31'd0, d[10]}, 32'd0);
    tick();
    rd(2'd0, d); chk("R7 timeout after 3 chars", {31'd0, d[10]}, 32'd1);
    rxLevel = 5'd0; settle(); settle();
    rd(2'd0, d); chk("R7 cleared by empty", {31'd0, d[10]}, 32'd0);
    wr(2'd1, 32'h0000_0808);
    rxLevel = 5'd2;
    for (int i = 0; i < 5; i++) tick();
    rd(2'd0, d); chk("R7 zero disables", {31'd0, d[10]}, 32'd0);
    rxLevel = 5'd0; wr(2'd1, 32'h0001_0808);
  endtask

  task automatic t_modem();
    logic [31:0] d;
    @(negedge clk); modemEvent = 1'b1;
    @(negedge clk); modemEvent = 1'b0;
    settle();
    rd(2'd0, d); chk("R8 modem sticky", {31'd0, d[13]}, 32'd1);
    wr(2'd0, 32'h0000_0020);
    chk("R8 modem irq", {31'd0, irq}, 32'd1);
    wr(2'd0, 32'h0000_2020);
    settle();
    rd(2'd0, d); chk("R8 modem cleared", {31'd0, d[13]}, 32'd0);
    chk("R8 irq after clear", {31'd0, irq}, 32'd0);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_levels();
    logic [31:0] d;
    rxLevel = 5'd11; txLevel = 5'd6; settle();
    rd(2'd2, d); chk("R9 levels", d, 32'h0000_0B06);
    rd(2'd0, d); chk("R9 rx not empty", {31'd0, d[14]}, 32'd1);
    rxLevel = 5'd0; settle();
    rd(2'd0, d); chk("R9 rx empty", {31'd0, d[14]}, 32'd0);
    txLevel = 5'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_thr();
    t_tx();
    t_overrun();
    t_timeout();
    t_modem();
    t_levels();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule